// File: doc/BRIEF.md
# GPIO Bank with Edge-Triggered Interrupt

This block is a bank of 32 general-purpose I/O lines with a small memory-mapped register interface. Software selects, line by line, whether a line is an input or is driven from an output latch. It can read back the synchronized level of every line, and it can arm each line to catch rising edges, falling edges or both. Caught edges stay in a status register until software clears them by writing ones. A separate per-line mask decides which pending bits reach the single interrupt output. The status bits latch whatever the mask holds.

The direction, output and both edge-enable registers each have a pair of write-only alias addresses. One alias only sets bits and the other only clears them, so one line can be changed without a read-modify-write. The register bus is a simple single-cycle request: valid, write, byte address and write data. Read data is registered and appears on the cycle after a read request, then holds until the next read.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset the direction, output, rising-enable, falling-enable, mask and status registers are all zero, `pad_oe` and `pad_out` are zero and `irq` is low.
- R2: Bit i of the direction register (read/write at offset 0x0C) drives `pad_oe[i]`; 1 means output, 0 means input. `pad_out` always shows the output register.
- R3: Writing to a set alias forces to 1 every target bit whose written bit is 1 and leaves the other bits alone. The set aliases are 0x18 (output), 0x54 (direction), 0x6C (rising enable) and 0x84 (falling enable).
- R4: Writing to a clear alias forces to 0 every target bit whose written bit is 1 and leaves the other bits alone. The clear aliases are 0x24 (output), 0x60 (direction), 0x78 (rising enable) and 0x90 (falling enable).
- R5: A read of offset 0x00 returns the line levels after a two-flop synchronizer, so a change on `pad_in` cannot be seen by a read issued in the same cycle. Writes to 0x00 have no effect.
- R6: A status bit (offset 0x48) becomes 1 on a rising edge of its synchronized line when its bit in the rising-enable register (0x30, read/write) is 1. It also becomes 1 on a falling edge when its bit in the falling-enable register (0x3C, read/write) is 1. With both enables set, either edge sets it.
- R7: An edge on a line whose matching enable bit is 0 leaves that line's status bit unchanged.
- R8: Writing 1 to a status bit clears it; status bits written as 0 keep their value.
- R9: When an enabled edge and a clearing write hit the same status bit in the same cycle, the bit ends up 1.
- R10: `irq` is high exactly when some line has both its status bit and its mask bit (offset 0x9C, read/write, 1 = enabled) at 1. Status bits latch whether or not they are masked.
- R11: Reads of the eight write-only alias offsets and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_vld | input | 1 | Register request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| pad_in | input | 32 | Asynchronous line levels from the pads |
| pad_out | output | 32 | Output latch value toward the pads |
| pad_oe | output | 32 | Per-line output enable (direction) |
| irq | output | 1 | Interrupt: OR of status AND mask |

## Verification
The hardest case to reach from the ports is a clearing write to the status register that lands in the same clock as a new edge event on that same bit. The event only appears three edges after the pad changes, counting two synchronizer stages and the previous-value register. The stimulus changes the pad on a falling clock edge and waits two rising edges. It then issues the write-one-to-clear so that it is sampled on the third rising edge, the one where the event latches, and reads back status to confirm that the bit survived. A control case, the same clear with no edge pending, shows that the write really clears the bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 8;

    // Register selector decoded from the byte offset
    typedef enum logic [3:0] {
        SEL_LEVEL    = 4'd0,
        SEL_DIR      = 4'd1,
        SEL_OUT_SET  = 4'd2,
        SEL_OUT_CLR  = 4'd3,
        SEL_RISE     = 4'd4,
        SEL_FALL     = 4'd5,
        SEL_STAT     = 4'd6,
        SEL_DIR_SET  = 4'd7,
        SEL_DIR_CLR  = 4'd8,
        SEL_RISE_SET = 4'd9,
        SEL_RISE_CLR = 4'd10,
        SEL_FALL_SET = 4'd11,
        SEL_FALL_CLR = 4'd12,
        SEL_MASK     = 4'd13,
        SEL_NONE     = 4'd15
    } reg_sel_e;

    // Indices of the four registers that carry set/clear aliases
    localparam int CTL_DIR  = 0;
    localparam int CTL_OUT  = 1;
    localparam int CTL_RISE = 2;
    localparam int CTL_FALL = 3;
    localparam int CTL_CNT  = 4;

    typedef struct packed {
        logic     wr_en;
        logic     rd_en;
        reg_sel_e sel;
    } bus_cmd_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            8'h00:   s = SEL_LEVEL;
            8'h0C:   s = SEL_DIR;
            8'h18:   s = SEL_OUT_SET;
            8'h24:   s = SEL_OUT_CLR;
            8'h30:   s = SEL_RISE;
            8'h3C:   s = SEL_FALL;
            8'h48:   s = SEL_STAT;
            8'h54:   s = SEL_DIR_SET;
            8'h60:   s = SEL_DIR_CLR;
            8'h6C:   s = SEL_RISE_SET;
            8'h78:   s = SEL_RISE_CLR;
            8'h84:   s = SEL_FALL_SET;
            8'h90:   s = SEL_FALL_CLR;
            8'h9C:   s = SEL_MASK;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic is_write_only(input reg_sel_e s);
        return (s == SEL_OUT_SET)  || (s == SEL_OUT_CLR)  ||
               (s == SEL_DIR_SET)  || (s == SEL_DIR_CLR)  ||
               (s == SEL_RISE_SET) || (s == SEL_RISE_CLR) ||
               (s == SEL_FALL_SET) || (s == SEL_FALL_CLR);
    endfunction

    // Direct read/write address of a control register (SEL_NONE if none)
    function automatic reg_sel_e ctl_direct(input int idx);
        case (idx)
            CTL_DIR:  return SEL_DIR;
            CTL_RISE: return SEL_RISE;
            CTL_FALL: return SEL_FALL;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic reg_sel_e ctl_set(input int idx);
        case (idx)
            CTL_DIR:  return SEL_DIR_SET;
            CTL_OUT:  return SEL_OUT_SET;
            CTL_RISE: return SEL_RISE_SET;
            default:  return SEL_FALL_SET;
        endcase
    endfunction

    function automatic reg_sel_e ctl_clr(input int idx);
        case (idx)
            CTL_DIR:  return SEL_DIR_CLR;
            CTL_OUT:  return SEL_OUT_CLR;
            CTL_RISE: return SEL_RISE_CLR;
            default:  return SEL_FALL_CLR;
        endcase
    endfunction

endpackage

// File: rtl/gpio_input_sync.sv
module gpio_input_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[0] <= '0;
                else     chain_q[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '0;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_bank_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_cmd_t           cmd,
    input  logic [N_LINES-1:0] wdata,
    output logic [N_LINES-1:0] dir,
    output logic [N_LINES-1:0] out,
    output logic [N_LINES-1:0] rise_en,
    output logic [N_LINES-1:0] fall_en,
    output logic [N_LINES-1:0] mask
);
    logic [N_LINES-1:0] ctl_q [CTL_CNT];
    logic [N_LINES-1:0] mask_q;

    for (genvar g = 0; g < CTL_CNT; g++) begin : g_ctl
        localparam reg_sel_e DIRECT_SEL = ctl_direct(g);
        localparam reg_sel_e SET_SEL    = ctl_set(g);
        localparam reg_sel_e CLR_SEL    = ctl_clr(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q[g] <= '0;
            end else if (cmd.wr_en) begin
                if (DIRECT_SEL != SEL_NONE && cmd.sel == DIRECT_SEL)
                    ctl_q[g] <= wdata;
                else if (cmd.sel == SET_SEL)
                    ctl_q[g] <= ctl_q[g] | wdata;
                else if (cmd.sel == CLR_SEL)
                    ctl_q[g] <= ctl_q[g] & ~wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (cmd.wr_en && cmd.sel == SEL_MASK)
            mask_q <= wdata;
    end

    assign dir     = ctl_q[CTL_DIR];
    assign out     = ctl_q[CTL_OUT];
    assign rise_en = ctl_q[CTL_RISE];
    assign fall_en = ctl_q[CTL_FALL];
    assign mask    = mask_q;

    // R3
    dir_set_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_en && cmd.sel == SEL_DIR_SET) |=> ((dir & $past(wdata)) == $past(wdata)));

    // R3
    set_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_en && cmd.sel == SEL_RISE_SET) |=> ((rise_en & $past(rise_en)) == $past(rise_en)));

    // R4
    out_clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_en && cmd.sel == SEL_OUT_CLR) |=> ((out & $past(wdata)) == '0));

    // R4
    clr_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_en && cmd.sel == SEL_FALL_CLR) |=> ((fall_en & ~$past(wdata)) == ($past(fall_en) & ~$past(wdata))));
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] level,
    input  logic [N_LINES-1:0] rise_en,
    input  logic [N_LINES-1:0] fall_en,
    input  logic [N_LINES-1:0] clr_bits,
    output logic [N_LINES-1:0] status
);
    logic [N_LINES-1:0] prev_q;
    logic [N_LINES-1:0] status_q;
    logic [N_LINES-1:0] event_bits;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    assign event_bits = (level & ~prev_q & rise_en) | (~level & prev_q & fall_en);

    // Event set has priority over the write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_bits) | event_bits;
    end

    assign status = status_q;

    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((level == prev_q) && (clr_bits == '0)) |=> (status == $past(status)));

    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_bits != '0) |=> ((status & $past(clr_bits & ~event_bits)) == '0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_bits & event_bits) != '0) |=> ((status & $past(clr_bits & event_bits)) == $past(clr_bits & event_bits)));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int N_LINES     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_vld,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [N_LINES-1:0]   bus_wdata,
    output logic [N_LINES-1:0]   bus_rdata,
    input  logic [N_LINES-1:0]   pad_in,
    output logic [N_LINES-1:0]   pad_out,
    output logic [N_LINES-1:0]   pad_oe,
    output logic                 irq
);
    bus_cmd_t           cmd;
    logic [N_LINES-1:0] level;
    logic [N_LINES-1:0] dir, out, rise_en, fall_en, mask;
    logic [N_LINES-1:0] status;
    logic [N_LINES-1:0] clr_bits;
    logic [N_LINES-1:0] rd_mux;
    logic [N_LINES-1:0] rdata_q;

    always_comb begin
        cmd.sel   = decode_offset(bus_addr);
        cmd.wr_en = bus_vld && bus_wr;
        cmd.rd_en = bus_vld && !bus_wr;
    end

    gpio_input_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (level)
    );

    gpio_ctrl_regs #(.N_LINES(N_LINES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wdata   (bus_wdata),
        .dir     (dir),
        .out     (out),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .mask    (mask)
    );

    assign clr_bits = (cmd.wr_en && cmd.sel == SEL_STAT) ? bus_wdata : '0;

    gpio_edge_latch #(.N_LINES(N_LINES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .level    (level),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .clr_bits (clr_bits),
        .status   (status)
    );

    always_comb begin
        case (cmd.sel)
            SEL_LEVEL: rd_mux = level;
            SEL_DIR:   rd_mux = dir;
            SEL_RISE:  rd_mux = rise_en;
            SEL_FALL:  rd_mux = fall_en;
            SEL_STAT:  rd_mux = status;
            SEL_MASK:  rd_mux = mask;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            rdata_q <= '0;
        else if (cmd.rd_en) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign pad_out   = out;
    assign pad_oe    = dir;
    assign irq       = |(status & mask);

    // R11
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd_en && (is_write_only(cmd.sel) || cmd.sel == SEL_NONE)) |=> (bus_rdata == '0));

    // R10
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask != '0) && (status != '0));

    // R2
    oe_follows_dir_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_en && cmd.sel == SEL_DIR) |=> (pad_oe == $past(bus_wdata)));
endmodule

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_vld = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_bank u0 (
        .clk(clk), .rst(rst), .bus_vld(bus_vld), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_vld = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_vld = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        bus_read(a, d);
        check(d == exp, tag, d, exp);
    endtask

    task automatic settle();
        repeat (3) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic set_pads_clear(input logic [31:0] v);
        pad_in = v;
        settle();
        bus_write(8'h48, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        check(pad_oe == 32'h0, "R1 pad_oe", pad_oe, 32'h0);
        check(pad_out == 32'h0, "R1 pad_out", pad_out, 32'h0);
        check(irq == 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
        read_check(8'h0C, 32'h0, "R1 dir");
        read_check(8'h30, 32'h0, "R1 rise_en");
        read_check(8'h3C, 32'h0, "R1 fall_en");
        read_check(8'h9C, 32'h0, "R1 mask");
        read_check(8'h48, 32'h0, "R1 status");
    endtask

    task automatic t_dir_out();
        bus_write(8'h0C, 32'h0000_FFFF);
        check(pad_oe == 32'h0000_FFFF, "R2 pad_oe", pad_oe, 32'h0000_FFFF);
        read_check(8'h0C, 32'h0000_FFFF, "R2 dir readback");
        bus_write(8'h18, 32'hA5A5_A5A5);
        check(pad_out == 32'hA5A5_A5A5, "R3 out set", pad_out, 32'hA5A5_A5A5);
        bus_write(8'h18, 32'h0000_0002);
        check(pad_out == 32'hA5A5_A5A7, "R3 out set keeps", pad_out, 32'hA5A5_A5A7);
        bus_write(8'h24, 32'h0000_00FF);
        check(pad_out == 32'hA5A5_A500, "R4 out clr", pad_out, 32'hA5A5_A500);
    endtask

    task automatic t_aliases();
        bus_write(8'h54, 32'hF000_0000);
        read_check(8'h0C, 32'hF000_FFFF, "R3 dir set");
        bus_write(8'h60, 32'h0000_000F);
        read_check(8'h0C, 32'hF000_FFF0, "R4 dir clr");
        check(pad_oe == 32'hF000_FFF0, "R2 pad_oe after aliases", pad_oe, 32'hF000_FFF0);
        bus_write(8'h6C, 32'h0000_0003);
        bus_write(8'h78, 32'h0000_0001);
        read_check(8'h30, 32'h0000_0002, "R3 R4 rise aliases");
        bus_write(8'h84, 32'h0000_0006);
        bus_write(8'h90, 32'h0000_0004);
        read_check(8'h3C, 32'h0000_0002, "R3 R4 fall aliases");
        bus_write(8'h30, 32'h0);
        bus_write(8'h3C, 32'h0);
    endtask

    task automatic t_level();
        pad_in = 32'h1234_5678;
        read_check(8'h00, 32'h0, "R5 level not yet synchronized");
        settle();
        read_check(8'h00, 32'h1234_5678, "R5 level after sync");
        bus_write(8'h00, 32'hFFFF_FFFF);
        read_check(8'h00, 32'h1234_5678, "R5 write to level ignored");
        read_check(8'h48, 32'h0, "R7 no status without enables");
        set_pads_clear(32'h0);
    endtask

    task automatic t_edges();
        bus_write(8'h30, 32'h0000_0005);
        bus_write(8'h3C, 32'h0000_0006);
        pad_in = 32'h0000_000F;
        settle();
        read_check(8'h48, 32'h0000_0005, "R6 R7 rising edges");
        bus_write(8'h48, 32'hFFFF_FFFF);
        pad_in = 32'h0;
        settle();
        read_check(8'h48, 32'h0000_0006, "R6 R7 falling edges");
        bus_write(8'h48, 32'hFFFF_FFFF);
    endtask

    task automatic t_w1c();
        pad_in = 32'h0000_0005;
        settle();
        read_check(8'h48, 32'h0000_0005, "R6 status before clear");
        bus_write(8'h48, 32'h0000_0001);
        read_check(8'h48, 32'h0000_0004, "R8 clear one bit");
        bus_write(8'h48, 32'h0000_0000);
        read_check(8'h48, 32'h0000_0004, "R8 zero write keeps");
        bus_write(8'h48, 32'h0000_0004);
        read_check(8'h48, 32'h0000_0000, "R8 clear last bit");
    endtask

    task automatic t_set_wins();
        // pad bit2 falls; falling enable on bit2; clear lands on the latch cycle
        pad_in = 32'h0000_0001;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        bus_write(8'h48, 32'h0000_0004);
        read_check(8'h48, 32'h0000_0004, "R9 event beats clear");
        bus_write(8'h48, 32'h0000_0004);
        read_check(8'h48, 32'h0000_0000, "R9 control clear without event");
        set_pads_clear(32'h0);
    endtask

    task automatic t_irq();
        bus_write(8'h6C, 32'h0000_0020);
        pad_in = 32'h0000_0020;
        settle();
        check(irq == 1'b0, "R10 masked irq low", {31'h0, irq}, 32'h0);
        read_check(8'h48, 32'h0000_0020, "R10 status latches while masked");
        bus_write(8'h9C, 32'h0000_0020);
        check(irq == 1'b1, "R10 irq after unmask", {31'h0, irq}, 32'h1);
        read_check(8'h9C, 32'h0000_0020, "R10 mask readback");
        bus_write(8'h9C, 32'h0000_0010);
        check(irq == 1'b0, "R10 other mask bit", {31'h0, irq}, 32'h0);
        bus_write(8'h9C, 32'h0000_0020);
        bus_write(8'h48, 32'h0000_0020);
        check(irq == 1'b0, "R10 irq after clear", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_wo_reads();
        logic [7:0] addrs [10] = '{8'h18, 8'h24, 8'h54, 8'h60, 8'h6C,
                                   8'h78, 8'h84, 8'h90, 8'h04, 8'hA0};
        bus_write(8'h30, 32'hFFFF_FFFF);
        bus_write(8'h3C, 32'hFFFF_FFFF);
        for (int i = 0; i < 10; i++)
            read_check(addrs[i], 32'h0, $sformatf("R11 read of 0x%02h", addrs[i]));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dir_out();
        t_aliases();
        t_level();
        t_edges();
        t_w1c();
        t_set_wins();
        t_irq();
        t_wo_reads();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule